// File: doc/BRIEF.md
# Multi-depth pixel decoder and serializer

The block takes one fetched screen byte and plays it out as a run of 3-bit RGB pixels. A byte holds 8, 4 or 2 pixels, depending on the selected colour depth of 1, 2 or 4 bits per pixel. In the multi-bit depths, a pixel's bits are not packed next to each other in the byte. They are spread across the byte with a fixed stride. Each pixel is repeated for 1, 2 or 4 clocks, so that a lower horizontal resolution still fills the same scan width.

A fetch engine presents the byte together with a ready flag. The byte is taken on a clock edge where the phase-0 strobe is high and the serializer is idle. From the next cycle the block raises `busy` and walks through the pixels. A row-spacing qualifier blanks the output without stopping the walk.

The logical colour of a pixel goes straight to the output, reduced to its low three bits. There is no palette lookup.

Top module: `pix_serializer`

## Requirements
- R1: The byte is loaded on a rising clock edge where `phase0`, `dataReady` and the inverse of `busy` are all high. `busy` reads 1 in the following cycle and pixel 0 is on `rgb`. No load happens if either `phase0` or `dataReady` is low.
- R2: With depth code 0 (1 bit per pixel), 8 pixels are emitted. Pixel n is byte bit (7-n), so bit 7 comes out first.
- R3: With depth code 1 (2 bits per pixel), 4 pixels are emitted. Pixel n has colour bit 1 = byte bit (7-n) and colour bit 0 = byte bit (3-n).
- R4: With depth code 2 (4 bits per pixel), 2 pixels are emitted.
  - Pixel 0 is the nibble {b7,b5,b3,b1}, most significant bit first.
  - Pixel 1 is the nibble {b6,b4,b2,b0}.
  - The nibble is reduced modulo 8 before output.
- R5: `rgb[0]` is red and carries colour bit 0. `rgb[1]` is green and carries colour bit 1. `rgb[2]` is blue and carries colour bit 2.
- R6: Each pixel is held for 1, 2 or 4 consecutive clocks, for scale codes 0, 1 and 2. Scale code 3 also holds for 4 clocks.
- R7: Depth code 3 behaves exactly like depth code 2.
- R8: `busy` stays high for exactly (pixels per byte × hold) cycles. It then falls, and `rgb` returns to 0.
- R9: `rgb` is 0 whenever `busy` is low or `spacingLine` is high. While `spacingLine` is high, the pixel walk and `busy` carry on unchanged.
- R10: A load request made while `busy` is high is ignored. The byte being emitted is not disturbed.
- R11: `depthSel`, `scaleSel` and `byteIn` are sampled only at load. Changing them mid-byte does not alter the pixels or the timing of the byte being emitted.
- R12: After reset, `busy` is 0 and `rgb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteIn | input | 8 | Fetched screen byte |
| dataReady | input | 1 | Byte on `byteIn` is valid |
| phase0 | input | 1 | Load-slot strobe |
| depthSel | input | 2 | Depth code: 0 = 1 bit per pixel, 1 = 2 bits per pixel, 2 or 3 = 4 bits per pixel |
| scaleSel | input | 2 | Hold code: 0 = 1 clock, 1 = 2 clocks, 2 or 3 = 4 clocks |
| spacingLine | input | 1 | Current line is a blank row-spacing line |
| rgb | output | 3 | Pixel colour: bit 0 red, bit 1 green, bit 2 blue |
| busy | output | 1 | Serializer is emitting a byte |

## Verification
The assertions assume that reset is applied before the first load request. They also assume that every input is settled before the clock edge, so `phase0` and `dataReady` are never unknown at an edge.

The mode-hold check assumes that the stored byte and mode change only in load cycles. The stimulus therefore changes `depthSel`, `scaleSel` and `byteIn` freely in the middle of a byte, and fires load requests while `busy` is high, to show that both are absorbed without effect.

All inputs are driven on the falling edge. The reserved depth and scale codes are exercised as well.

// File: rtl/pix_serializer_pkg.sv
package pix_serializer_pkg;

  localparam int DATA_W   = 8;
  localparam int COLOUR_W = 3;
  localparam int SEL_W    = $clog2(DATA_W);
  localparam int HOLD_W   = 2;

  typedef enum logic [1:0] {
    DEPTH1 = 2'd0,
    DEPTH2 = 2'd1,
    DEPTH4 = 2'd2
  } depth_e;

  typedef struct packed {
    logic             load;
    logic             show;
    logic [SEL_W-1:0] sel;
  } strobe_t;

  function automatic depth_e toDepth(input logic [1:0] code);
    case (code)
      2'd0:    return DEPTH1;
      2'd1:    return DEPTH2;
      default: return DEPTH4;
    endcase
  endfunction

  function automatic logic [SEL_W-1:0] lastSel(input depth_e d);
    case (d)
      DEPTH1:  return SEL_W'(7);
      DEPTH2:  return SEL_W'(3);
      default: return SEL_W'(1);
    endcase
  endfunction

  function automatic logic [HOLD_W-1:0] holdTop(input logic [1:0] code);
    case (code)
      2'd0:    return HOLD_W'(0);
      2'd1:    return HOLD_W'(1);
      default: return HOLD_W'(3);
    endcase
  endfunction

endpackage

// File: rtl/pix_serializer_ctrl.sv
module pix_serializer_ctrl
  import pix_serializer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       dataReady,
  input  logic       phase0,
  input  logic [1:0] depthSel,
  input  logic [1:0] scaleSel,
  output strobe_t    strobes,
  output logic       busy
);

  logic              busyQ;
  logic [SEL_W-1:0]  selQ;
  logic [SEL_W-1:0]  lastQ;
  logic [HOLD_W-1:0] holdQ;
  logic [HOLD_W-1:0] holdTopQ;
  logic              loadReq;
  logic              atLast;

  assign loadReq = phase0 && dataReady && !busyQ;
  assign atLast  = (selQ == lastQ) && (holdQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      selQ     <= '0;
      lastQ    <= '0;
      holdQ    <= '0;
      holdTopQ <= '0;
    end else if (loadReq) begin
      busyQ    <= 1'b1;
      selQ     <= '0;
      lastQ    <= lastSel(toDepth(depthSel));
      holdQ    <= holdTop(scaleSel);
      holdTopQ <= holdTop(scaleSel);
    end else if (busyQ) begin
      if (holdQ == '0) begin
        holdQ <= holdTopQ;
        if (selQ == lastQ) busyQ <= 1'b0;
        else               selQ  <= selQ + SEL_W'(1);
      end else begin
        holdQ <= holdQ - HOLD_W'(1);
      end
    end
  end

  assign strobes.load = loadReq;
  assign strobes.show = busyQ;
  assign strobes.sel  = selQ;
  assign busy         = busyQ;

  // R1
  load_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase0 && dataReady && !busy) |=> (busy && selQ == '0));

  // R6
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && holdQ != '0) |=> (busy && $stable(selQ)));

  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(atLast));

  // R10
  no_early_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !atLast) |=> busy);

endmodule

// File: rtl/pix_serializer_dp.sv
module pix_serializer_dp
  import pix_serializer_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [DATA_W-1:0]   byteIn,
  input  logic [1:0]          depthSel,
  input  logic                spacingLine,
  input  strobe_t             strobes,
  output logic [COLOUR_W-1:0] rgb
);

  logic [DATA_W-1:0]   byteQ;
  depth_e              depthQ;
  logic [SEL_W-1:0]    pos7, pos5, pos3, pos1;
  logic [COLOUR_W-1:0] colour;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteQ  <= '0;
      depthQ <= DEPTH1;
    end else if (strobes.load) begin
      byteQ  <= byteIn;
      depthQ <= toDepth(depthSel);
    end
  end

  assign pos7 = SEL_W'(7) - strobes.sel;
  assign pos5 = SEL_W'(5) - strobes.sel;
  assign pos3 = SEL_W'(3) - strobes.sel;
  assign pos1 = SEL_W'(1) - strobes.sel;

  always_comb begin
    case (depthQ)
      DEPTH1:  colour = {2'b00, byteQ[pos7]};
      DEPTH2:  colour = {1'b0, byteQ[pos7], byteQ[pos3]};
      default: colour = {byteQ[pos5], byteQ[pos3], byteQ[pos1]};
    endcase
  end

  for (genvar ch = 0; ch < COLOUR_W; ch++) begin : g_chan
    assign rgb[ch] = strobes.show && !spacingLine && colour[ch];
  end

  // R9
  blank_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.show || spacingLine) |-> (rgb == '0));

  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> ($stable(byteQ) && $stable(depthQ)));

endmodule

// File: rtl/pix_serializer.sv
module pix_serializer
  import pix_serializer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] byteIn,
  input  logic       dataReady,
  input  logic       phase0,
  input  logic [1:0] depthSel,
  input  logic [1:0] scaleSel,
  input  logic       spacingLine,
  output logic [2:0] rgb,
  output logic       busy
);

  strobe_t strobes;

  pix_serializer_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .dataReady (dataReady),
    .phase0    (phase0),
    .depthSel  (depthSel),
    .scaleSel  (scaleSel),
    .strobes   (strobes),
    .busy      (busy)
  );

  pix_serializer_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .byteIn      (byteIn),
    .depthSel    (depthSel),
    .spacingLine (spacingLine),
    .strobes     (strobes),
    .rgb         (rgb)
  );

  // R12
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (!busy && rgb == 3'd0));

endmodule

// File: tb/pix_serializer_test.sv
module pix_serializer_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] byteIn = '0;
  logic       dataReady = 1'b0;
  logic       phase0 = 1'b0;
  logic [1:0] depthSel = '0;
  logic [1:0] scaleSel = '0;
  logic       spacingLine = 1'b0;
  logic [2:0] rgb;
  logic       busy;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  pix_serializer uut (
    .clk(clk), .rstN(rstN), .byteIn(byteIn), .dataReady(dataReady),
    .phase0(phase0), .depthSel(depthSel), .scaleSel(scaleSel),
    .spacingLine(spacingLine), .rgb(rgb), .busy(busy)
  );

  // {byte, depth code, scale code, pixel7 .. pixel0}
  localparam logic [35:0] VECS [9] = '{
    {8'hA5, 2'd0, 2'd0, 3'd1, 3'd0, 3'd1, 3'd0, 3'd0, 3'd1, 3'd0, 3'd1},
    {8'h5A, 2'd0, 2'd1, 3'd0, 3'd1, 3'd0, 3'd1, 3'd1, 3'd0, 3'd1, 3'd0},
    {8'hC9, 2'd1, 2'd1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd1, 3'd0, 3'd2, 3'd3},
    {8'hF0, 2'd2, 2'd2, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd4, 3'd4},
    {8'h2D, 2'd2, 2'd2, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd3, 3'd6},
    {8'h3C, 2'd1, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd2, 3'd2, 3'd1, 3'd1},
    {8'hAA, 2'd2, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd7},
    {8'h81, 2'd0, 2'd2, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd1},
    {8'h2D, 2'd3, 2'd3, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd3, 3'd6}
  };

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int pixCount(input logic [1:0] d);
    return (d == 2'd0) ? 8 : (d == 2'd1) ? 4 : 2;
  endfunction

  function automatic int holdLen(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  // Load one byte at the next edge and follow every output cycle.
  // A load request with other byte and mode values is fired at sample poke.
  task automatic runByte(input logic [7:0] b, input logic [1:0] d, input logic [1:0] s,
                         input logic [23:0] expv, input logic blank, input int poke,
                         input string tag);
    int npix = pixCount(d);
    int hold = holdLen(s);
    int expC;
    byteIn = b; depthSel = d; scaleSel = s; spacingLine = blank;
    phase0 = 1'b1; dataReady = 1'b1;
    @(posedge clk); @(negedge clk);
    phase0 = 1'b0; dataReady = 1'b0;
    for (int k = 0; k < npix * hold; k++) begin
      expC = blank ? 0 : int'(expv[3*(k/hold) +: 3]);
      check(busy === 1'b1, {tag, " R8 busy"}, int'(busy), 1);
      check(rgb === 3'(expC), {tag, " R6 pixel"}, int'(rgb), expC);
      if (k == poke) begin
        byteIn = ~b; depthSel = d ^ 2'd1; scaleSel = ~s;
        phase0 = 1'b1; dataReady = 1'b1;
      end else begin
        phase0 = 1'b0; dataReady = 1'b0;
      end
      @(negedge clk);
    end
    check(busy === 1'b0, {tag, " R8 end"}, int'(busy), 0);
    check(rgb === 3'd0, {tag, " R9 idle"}, int'(rgb), 0);
    spacingLine = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(busy === 1'b0, "R12 busy", int'(busy), 0);
    check(rgb === 3'd0, "R12 rgb", int'(rgb), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 9; v++) begin
      tag = (VECS[v][27:26] == 2'd0) ? "R2" :
            (VECS[v][27:26] == 2'd1) ? "R3" :
            (VECS[v][27:26] == 2'd2) ? "R4" : "R7";
      runByte(VECS[v][35:28], VECS[v][27:26], VECS[v][25:24], VECS[v][23:0],
              1'b0, -1, tag);
      @(negedge clk);
    end

    // R1: no load without phase0, no load without dataReady
    dataReady = 1'b1; phase0 = 1'b0;
    @(negedge clk); @(negedge clk);
    check(busy === 1'b0, "R1 no phase0", int'(busy), 0);
    dataReady = 1'b0; phase0 = 1'b1;
    @(negedge clk); @(negedge clk);
    check(busy === 1'b0, "R1 no ready", int'(busy), 0);
    phase0 = 1'b0;

    // R5: colour 1 lights red only; colour 4 lights blue only
    runByte(8'h80, 2'd0, 2'd0, {21'd0, 3'd1}, 1'b0, -1, "R5 red");
    check(rgb[0] === 1'b0, "R5 red off", int'(rgb), 0);
    runByte(8'h20, 2'd2, 2'd0, {21'd0, 3'd4}, 1'b0, -1, "R5 blue");

    // R9: spacing line blanks output while the walk continues
    runByte(8'hFF, 2'd0, 2'd0, {8{3'd1}}, 1'b1, -1, "R9 spacing");

    // R10 and R11: request and mode change mid-byte are absorbed
    runByte(8'hA5, 2'd0, 2'd2, {3'd1, 3'd0, 3'd1, 3'd0, 3'd0, 3'd1, 3'd0, 3'd1},
            1'b0, 5, "R10 R11 busy-load");
    runByte(8'hC9, 2'd1, 2'd0, {12'd0, 3'd1, 3'd0, 3'd2, 3'd3},
            1'b0, 1, "R10 R11 short");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule